// File: doc/BRIEF.md
# Breaker Opening Sequencer with Zero-Current Release

This block drives the opening of one circuit breaker inside a digital protection controller. A trip command from the protection logic starts an intentional delay that lasts a fixed number of fundamental power cycles. The delay is counted in sample strobes: with the default settings it is two cycles at sixteen samples per cycle.

Once the delay has run out, the block does not open at once. It waits for a strobed current sample that lies inside a programmable zero band, or for a sample whose sign differs from the previous strobed sample. On that sample the switch-open output is asserted. The output then stays asserted until reset.

A two-bit status word always reports the current phase of the sequence. Each breaker has its own instance of the block and its own trip input.

Top module: `breaker_opener`

## Requirements
- R1: After a synchronous reset, status is 00 (closed) and the switch-open output is 0.
- R2: While closed, a trip input that is high at one clock edge, even for a single clock and between strobes, moves status to 01 (delaying) on the next cycle.
- R3: The delay lasts DELAY_CYCLES*SAMPLES_PER_CYCLE strobes (32 by default) counted from entry into delaying. The cycle after the 32nd strobe, status becomes 10 (waiting for zero). Clocks without a strobe do not count.
- R4: Trip pulses during delaying are ignored: they neither restart nor extend the count.
- R5: While waiting, a strobed sample whose magnitude is at or below the unsigned zero-band input sets status to 11 and the switch-open output to 1 on the next cycle.
- R6: While waiting, a strobed sample whose sign bit (the MSB, zero counting as non-negative) differs from the previous strobed sample opens the breaker in the same way. The previous sample is whatever sample was strobed last, in any state.
- R7: Sample values presented without a strobe have no effect on the sequence.
- R8: Once open, status stays 11 and the output stays 1 until reset, whatever trip, strobe and sample do.
- R9: The switch-open output is 1 exactly when status is 11.
- R10: The most negative sample, -2^(W-1), has magnitude 2^(W-1) when it is compared with the zero band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_i | input | 1 | Trip command from protection logic |
| smp_stb_i | input | 1 | Sample strobe, one clock per current sample |
| smp_i | input | SMP_W | Signed two's-complement current sample |
| zband_i | input | SMP_W | Unsigned zero-band magnitude threshold |
| open_o | output | 1 | Switch-open control |
| status_o | output | 2 | 00 closed, 01 delaying, 10 waiting for zero, 11 open |

## Verification
Every result of the block is registered once. A trip, the strobe that ends the delay, or the strobe that carries a qualifying sample shows up on the status and open outputs exactly one clock later. The bench applies its inputs just after the falling edge. It advances a behavioural model by one step for that rising edge, and compares the outputs at the next falling edge. In this way every comparison falls exactly one edge after the stimulus that caused it.

// File: rtl/brk_pkg.sv
package brk_pkg;

    typedef enum logic [1:0] {
        ST_CLOSED = 2'b00,
        ST_DELAY  = 2'b01,
        ST_WAIT   = 2'b10,
        ST_OPEN   = 2'b11
    } brk_state_e;

    // Number of sample strobes that make up the intentional delay.
    function automatic int unsigned delay_strobes(input int unsigned cycles,
                                                  input int unsigned per_cycle);
        return cycles * per_cycle;
    endfunction

endpackage

// File: rtl/brk_delay_count.sv
module brk_delay_count #(
    parameter int unsigned LIMIT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic stb_i,
    output logic done_o
);
    localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt <= '0;
        end else if (stb_i && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done_o = en_i && stb_i && (cnt == LAST);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST); // R3
    AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en_i && !stb_i) |=> (cnt == $past(cnt))); // R3

endmodule

// File: rtl/brk_zero_detect.sv
module brk_zero_detect #(
    parameter int unsigned SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb_i,
    input  logic [SMP_W-1:0] smp_i,
    input  logic [SMP_W-1:0] zband_i,
    output logic             hit_o
);
    logic             prev_neg;
    logic             prev_vld;
    logic [SMP_W-1:0] mag;
    logic             in_band;
    logic             flip;

    always_comb begin
        mag     = smp_i[SMP_W-1] ? (~smp_i + 1'b1) : smp_i;
        in_band = (mag <= zband_i);
        flip    = prev_vld && (prev_neg != smp_i[SMP_W-1]);
        hit_o   = stb_i && (in_band || flip);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_neg <= 1'b0;
            prev_vld <= 1'b0;
        end else if (stb_i) begin
            prev_neg <= smp_i[SMP_W-1];
            prev_vld <= 1'b1;
        end
    end

    AST_HIT_NEEDS_STB: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> stb_i); // R7
    AST_PREV_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stb_i |=> $stable(prev_neg)); // R6

endmodule

// File: rtl/brk_fsm.sv
module brk_fsm
    import brk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trip_i,
    input  logic       stb_i,
    input  logic       delay_done_i,
    input  logic       zero_hit_i,
    output brk_state_e state_o
);
    brk_state_e st, st_nx;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_CLOSED: if (trip_i)       st_nx = ST_DELAY;
            ST_DELAY:  if (delay_done_i) st_nx = ST_WAIT;
            ST_WAIT:   if (zero_hit_i)   st_nx = ST_OPEN;
            ST_OPEN:                     st_nx = ST_OPEN;
            default:                     st_nx = ST_CLOSED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_CLOSED;
        else     st <= st_nx;
    end

    assign state_o = st;

    AST_TRIP_START: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CLOSED && trip_i) |=> (st == ST_DELAY)); // R2
    AST_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CLOSED) |=> (st == ST_CLOSED || st == ST_DELAY)); // R3
    AST_DELAY_EXIT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DELAY) |=> (st == ST_DELAY || st == ST_WAIT)); // R4
    AST_WAIT_STROBED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && !stb_i) |=> (st == ST_WAIT)); // R7
    AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPEN) |=> (st == ST_OPEN)); // R8

endmodule

// File: rtl/breaker_opener.sv
module breaker_opener
    import brk_pkg::*;
#(
    parameter int unsigned SMP_W             = 16,
    parameter int unsigned SAMPLES_PER_CYCLE = 16,
    parameter int unsigned DELAY_CYCLES      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trip_i,
    input  logic             smp_stb_i,
    input  logic [SMP_W-1:0] smp_i,
    input  logic [SMP_W-1:0] zband_i,
    output logic             open_o,
    output logic [1:0]       status_o
);
    localparam int unsigned DELAY_STB = delay_strobes(DELAY_CYCLES, SAMPLES_PER_CYCLE);

    brk_state_e state;
    logic       delay_done;
    logic       zero_hit;

    brk_delay_count #(.LIMIT(DELAY_STB)) u_delay (
        .clk    (clk),
        .rst    (rst),
        .en_i   (state == ST_DELAY),
        .stb_i  (smp_stb_i),
        .done_o (delay_done)
    );

    brk_zero_detect #(.SMP_W(SMP_W)) u_zero (
        .clk     (clk),
        .rst     (rst),
        .stb_i   (smp_stb_i),
        .smp_i   (smp_i),
        .zband_i (zband_i),
        .hit_o   (zero_hit)
    );

    brk_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .trip_i       (trip_i),
        .stb_i        (smp_stb_i),
        .delay_done_i (delay_done),
        .zero_hit_i   (zero_hit),
        .state_o      (state)
    );

    assign status_o = state;
    assign open_o   = (state == ST_OPEN);

    AST_OPEN_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(open_o) |-> $past(zero_hit)); // R5
    AST_WAIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (status_o == 2'b10 && $past(status_o) == 2'b01) |-> $past(delay_done)); // R3

endmodule

// File: tb/test_breaker_opener.sv
module test_breaker_opener;
    localparam int W     = 16;
    localparam int DELAY = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         trip = 1'b0;
    logic         stb = 1'b0;
    logic [W-1:0] smp = '0;
    logic [W-1:0] zb = '0;
    logic         open_w;
    logic [1:0]   status_w;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // behavioural reference: 0 closed, 1 delaying, 2 waiting, 3 open
    int m_st   = 0;
    int m_cnt  = 0;
    int m_prev = 0;
    bit m_pv   = 1'b0;

    always #2.5 clk = ~clk;

    breaker_opener i_breaker_opener (
        .clk(clk), .rst(rst), .trip_i(trip), .smp_stb_i(stb),
        .smp_i(smp), .zband_i(zb), .open_o(open_w), .status_o(status_w)
    );

    function automatic string tag_of(int st);
        case (st)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic check_now(string tag);
        total++;
        if (status_w !== 2'(m_st)) begin
            bad++;
            $display("FAIL %s status actual=%0d expected=%0d t=%0t", tag, status_w, m_st, $time);
        end
        total++;
        if (open_w !== (m_st == 3)) begin // R9
            bad++;
            $display("FAIL R9 open actual=%0b expected=%0b t=%0t", open_w, (m_st == 3), $time);
        end
    endtask

    // one clock: check at the falling edge, drive, step the model, take the rising edge
    task automatic cyc(bit t, bit s, int v);
        int mag;
        @(negedge clk);
        if (!rst) check_now(tag_of(m_st));
        trip = t; stb = s; smp = W'(v);
        if (rst) begin
            m_st = 0; m_cnt = 0; m_pv = 1'b0; m_prev = 0;
        end else begin
            mag = (v < 0) ? -v : v;
            case (m_st)
                0: if (t) begin m_st = 1; m_cnt = 0; end
                1: if (s) begin m_cnt++; if (m_cnt == DELAY) m_st = 2; end
                2: if (s && (mag <= int'(zb) || (m_pv && ((v < 0) != (m_prev < 0))))) m_st = 3;
                default: ;
            endcase
            if (s) begin m_prev = v; m_pv = 1'b1; end
        end
        @(posedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) cyc(0, 0, 0);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_now("R1");
    endtask

    // complete the delay: n strobes of value v, every 3rd clock, with trips sprinkled in (R4)
    task automatic run_delay(int v);
        for (int i = 0; i < DELAY; i++) begin
            cyc(i % 5 == 0, 0, 0); // R4: trips during delaying ignored
            cyc(0, 0, -v);         // R7: unstrobed opposite sign ignored
            cyc(0, 1, v);
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // scenario A: in-band release, R2 single-clock trip, R3 count, R5, R8
        zb = 16'd5;
        do_reset();
        cyc(0, 0, 0);
        cyc(1, 0, 0);      // R2: one-clock pulse between strobes
        run_delay(1000);
        cyc(0, 0, 0);      // R3: waiting should now be reported
        cyc(0, 1, 1000);
        cyc(0, 0, 2);      // R7: unstrobed in-band sample
        cyc(0, 1, 900);
        cyc(0, 1, 3);      // R5: in band
        for (int i = 0; i < 20; i++) cyc(i % 2, i % 3 == 0, 0); // R8: sticky

        // scenario B: sign change release, R6
        zb = 16'd10;
        do_reset();
        cyc(1, 0, 0);
        run_delay(500);
        cyc(0, 1, 500);
        cyc(0, 1, 600);
        cyc(0, 1, -500);   // R6: sign flip
        repeat (4) cyc(0, 0, 0);

        // scenario C: zero counts as non-negative; R6 with previous from the delay phase
        zb = 16'd0;
        do_reset();
        cyc(1, 0, 0);
        run_delay(-700);
        cyc(0, 1, -1);
        cyc(0, 1, 0);      // R6: flip from negative to zero (also in band)
        repeat (3) cyc(0, 0, 0);

        // scenario D: most negative sample, R10
        zb = 16'd32767;
        do_reset();
        cyc(1, 0, 0);
        run_delay(-30000);
        cyc(0, 1, -32768); // R10: magnitude 32768 > 32767, same sign: stays waiting
        cyc(0, 0, 0);
        zb = 16'd32768;
        cyc(0, 1, -32768); // R10: now within band
        repeat (3) cyc(0, 0, 0);

        // scenario E: no strobe, no progress (R3, R7)
        do_reset();
        cyc(1, 0, 0);
        for (int i = 0; i < 50; i++) cyc(0, 0, 0);
        repeat (2) cyc(0, 0, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule